// File: doc/BRIEF.md
# DS2 Multiframe Multiplexer Transmitter

This block assembles the serial DS2 bit stream from four DS1 tributaries. It emits one bit per clock and walks through a fixed multiframe of 4 subframes. Each subframe holds 6 blocks, and each block holds one overhead bit followed by 48 information bits. The information bits are shared among the four tributaries in strict rotation. The block fetches each tributary bit through a request output that fires one cycle before the slot that bit goes into.

The overhead bits carry four things: the multiframe alignment pattern, a software-written spare bit, the frame alignment pattern, and per-tributary stuffing indicators. A stuff request for tributary n is captured at the start of subframe n. When it is set, the three indicator bits of that subframe are sent as ones. The first slot of tributary n in the last block of the subframe then carries a dummy bit, and no bit is fetched from the tributary for it. The stuffing decision itself, buffering and line coding belong to the surrounding logic.

Top module: `ds2_mux_tx`

## Requirements
- R1: The output follows a repeating 1176-cycle multiframe: 4 subframes of 6 blocks of 49 bits. `blkStart` is high on bit 0 of every block. `sfStart` is high on bit 0 of block 1 of every subframe. `mfStart` is high on bit 0 of block 1 of subframe 1.
- R2: Bit 0 of block 1 in subframes 1, 2 and 3 carries 0, 1 and 1 respectively.
- R3: Bit 0 of block 1 in subframe 4 carries a spare bit taken from a register. The register is 1 after reset. A cycle with `xBitWe` high loads it from `xBitIn`.
- R4: In every subframe, bit 0 of block 3 is 0 and bit 0 of block 6 is 1.
- R5: In subframe n (n = 1..4), bit 0 of blocks 2, 4 and 5 each equal `stuffReq[n-1]` as sampled in the first cycle of that subframe.
- R6: Information bit p (p = 1..48) of a block carries tributary (p-1) mod 4. The value sent is that tributary's `tribBit` input in the same cycle.
- R7: `tribReq[t]` is high exactly in the cycle before each information slot that takes a bit from tributary t. At most one request bit is high in any cycle.
- R8: When stuffing is active in subframe n, information bit n of block 6 (the first slot of tributary n-1 in that block) is sent as 0. No request is raised for that slot.
- R9: The first cycle after reset is bit 0 of block 1 of subframe 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, one DS2 bit per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| xBitWe | input | 1 | Write strobe for the spare-bit register |
| xBitIn | input | 1 | New value for the spare-bit register |
| stuffReq | input | 4 | Per-tributary stuff request, bit t for tributary t |
| tribBit | input | 4 | Current data bit offered by each tributary |
| tribReq | output | 4 | Per-tributary fetch request, one cycle ahead of its slot |
| ds2Data | output | 1 | Serial DS2 output bit |
| mfStart | output | 1 | First bit of a multiframe |
| sfStart | output | 1 | First bit of a subframe |
| blkStart | output | 1 | First bit of a block |

## Verification
The bench builds the block with its default 48 information bits per block, so every multiframe is the full 1176 bits long. Each multiframe applies one of the sixteen stuff-request patterns, so every combination of stuffed and unstuffed tributaries is covered. The bench compares every output bit, strobe and request against an arithmetic model of the frame position. Spare-bit writes of both values are placed between multiframes, and the reset value is checked in the first multiframe. This puts every overhead position, every dummy slot and every tributary rotation within reach.

// File: rtl/ds2_mux_pkg.sv
package ds2_mux_pkg;
  localparam int NUM_TRIB = 4;
  localparam int TRIB_W = $clog2(NUM_TRIB);
  localparam int NUM_BLK = 6;
  localparam int BLK_W = $clog2(NUM_BLK);

  typedef enum logic [1:0] {OH_ZERO, OH_ONE, OH_XBIT} ohKind_e;

  typedef struct packed {
    logic isOh;
    ohKind_e ohKind;
    logic isDummy;
    logic [TRIB_W-1:0] slotTrib;
  } slotCtl_t;
endpackage

// File: rtl/ds2_frame_ctl.sv
module ds2_frame_ctl
  import ds2_mux_pkg::*;
#(
  parameter int INFO_BITS = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_TRIB-1:0] stuffReq,
  output logic [NUM_TRIB-1:0] tribReq,
  output slotCtl_t ctl,
  output logic mfStart,
  output logic sfStart,
  output logic blkStart
);
  localparam int BLK_LEN = INFO_BITS + 1;
  localparam int BIT_W = $clog2(BLK_LEN);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BLK_LEN - 1);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLK - 1);
  localparam logic [TRIB_W-1:0] LAST_TRIB = TRIB_W'(NUM_TRIB - 1);

  logic [BIT_W-1:0] bitCnt;
  logic [BLK_W-1:0] blkCnt;
  logic [TRIB_W-1:0] sfCnt;
  logic [TRIB_W-1:0] slotCnt;
  logic stuffActive;
  logic [BIT_W-1:0] sfExt;
  logic [TRIB_W-1:0] nextTrib;
  logic nextIsInfo;
  logic nextDummy;
  logic [NUM_TRIB-1:0] slotOneHot;

  assign sfExt = {{(BIT_W-TRIB_W){1'b0}}, sfCnt};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      blkCnt <= '0;
      sfCnt <= '0;
      slotCnt <= '0;
      stuffActive <= 1'b0;
    end else begin
      if (bitCnt == LAST_BIT) begin
        bitCnt <= '0;
        if (blkCnt == LAST_BLK) begin
          blkCnt <= '0;
          sfCnt <= (sfCnt == LAST_TRIB) ? '0 : sfCnt + 1'b1;
        end else begin
          blkCnt <= blkCnt + 1'b1;
        end
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
      slotCnt <= (bitCnt == '0 || slotCnt == LAST_TRIB) ? '0 : slotCnt + 1'b1;
      if (bitCnt == '0 && blkCnt == '0) stuffActive <= stuffReq[sfCnt];
    end
  end

  always_comb begin
    nextTrib = (bitCnt == '0 || slotCnt == LAST_TRIB) ? '0 : slotCnt + 1'b1;
    nextIsInfo = (bitCnt != LAST_BIT);
    nextDummy = stuffActive && blkCnt == LAST_BLK && bitCnt == sfExt;
  end

  for (genvar t = 0; t < NUM_TRIB; t++) begin : g_req
    assign tribReq[t] = nextIsInfo && !nextDummy && nextTrib == TRIB_W'(t);
    assign slotOneHot[t] = ctl.slotTrib == TRIB_W'(t);
  end

  always_comb begin
    ctl.isOh = (bitCnt == '0);
    ctl.slotTrib = slotCnt;
    ctl.isDummy = stuffActive && blkCnt == LAST_BLK && bitCnt == sfExt + 1'b1;
    case (blkCnt)
      BLK_W'(0): ctl.ohKind = (sfCnt == '0) ? OH_ZERO :
                              (sfCnt == LAST_TRIB) ? OH_XBIT : OH_ONE;
      BLK_W'(2): ctl.ohKind = OH_ZERO;
      LAST_BLK:  ctl.ohKind = OH_ONE;
      default:   ctl.ohKind = stuffActive ? OH_ONE : OH_ZERO;
    endcase
  end

  assign blkStart = (bitCnt == '0);
  assign sfStart = blkStart && blkCnt == '0;
  assign mfStart = sfStart && sfCnt == '0;

  a_r1_bit_in_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);
  a_r1_block_longer_than_one: assert property (@(posedge clk) disable iff (!rstN)
    blkStart |=> !blkStart);
  a_r7_req_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tribReq));
  a_r7_req_then_owned_slot: assert property (@(posedge clk) disable iff (!rstN)
    (|tribReq) |=> (!ctl.isOh && !ctl.isDummy && $past(tribReq) == slotOneHot));
  a_r5_stuff_held: assert property (@(posedge clk) disable iff (!rstN)
    !sfStart |=> $stable(stuffActive));
endmodule

// File: rtl/ds2_frame_dp.sv
module ds2_frame_dp
  import ds2_mux_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic xBitWe,
  input  logic xBitIn,
  input  logic [NUM_TRIB-1:0] tribBit,
  input  slotCtl_t ctl,
  output logic ds2Data
);
  logic xReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xReg <= 1'b1;
    else if (xBitWe) xReg <= xBitIn;
  end

  always_comb begin
    if (ctl.isOh) begin
      case (ctl.ohKind)
        OH_ONE:  ds2Data = 1'b1;
        OH_XBIT: ds2Data = xReg;
        default: ds2Data = 1'b0;
      endcase
    end else if (ctl.isDummy) begin
      ds2Data = 1'b0;
    end else begin
      ds2Data = tribBit[ctl.slotTrib];
    end
  end

  a_r3_x_write: assert property (@(posedge clk) disable iff (!rstN)
    xBitWe |=> xReg == $past(xBitIn));
  a_r3_x_hold: assert property (@(posedge clk) disable iff (!rstN)
    !xBitWe |=> $stable(xReg));
endmodule

// File: rtl/ds2_mux_tx.sv
module ds2_mux_tx
  import ds2_mux_pkg::*;
#(
  parameter int INFO_BITS = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic xBitWe,
  input  logic xBitIn,
  input  logic [3:0] stuffReq,
  input  logic [3:0] tribBit,
  output logic [3:0] tribReq,
  output logic ds2Data,
  output logic mfStart,
  output logic sfStart,
  output logic blkStart
);
  slotCtl_t ctl;

  ds2_frame_ctl #(.INFO_BITS(INFO_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .stuffReq(stuffReq), .tribReq(tribReq),
    .ctl(ctl), .mfStart(mfStart), .sfStart(sfStart), .blkStart(blkStart)
  );

  ds2_frame_dp u_dp (
    .clk(clk), .rstN(rstN), .xBitWe(xBitWe), .xBitIn(xBitIn),
    .tribBit(tribBit), .ctl(ctl), .ds2Data(ds2Data)
  );
endmodule

// File: tb/tb_ds2_mux_tx.sv
`timescale 1ns/1ps
module tb_ds2_mux_tx;
  localparam int BLK_LEN = 49;
  localparam int SF_LEN = 6 * BLK_LEN;
  localparam int MF_LEN = 4 * SF_LEN;
  localparam int NUM_MF = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xBitWe = 1'b0;
  logic xBitIn = 1'b0;
  logic [3:0] stuffReq = 4'b0;
  logic [3:0] tribBit = 4'b0;
  logic [3:0] tribReq;
  logic ds2Data, mfStart, sfStart, blkStart;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ds2_mux_tx dut (
    .clk(clk), .rstN(rstN), .xBitWe(xBitWe), .xBitIn(xBitIn),
    .stuffReq(stuffReq), .tribBit(tribBit), .tribReq(tribReq),
    .ds2Data(ds2Data), .mfStart(mfStart), .sfStart(sfStart), .blkStart(blkStart)
  );

  function automatic logic patBit(int t, int k);
    return 1'((k * (t + 3) + (k >> 3) + t) & 1);
  endfunction

  task automatic check(string req, int pos, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pos %0d actual %0h expected %0h", req, pos, act, exp);
    end
  endtask

  int reqCnt [4];
  int useCnt [4];

  initial begin
    logic xExp;
    logic stuffLatch;
    logic wePending;
    logic xPending;
    xExp = 1'b1;
    stuffLatch = 1'b0;
    wePending = 1'b0;
    xPending = 1'b0;
    for (int t = 0; t < 4; t++) begin
      reqCnt[t] = 0;
      useCnt[t] = 0;
      tribBit[t] = patBit(t, 0);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int p = 0; p < NUM_MF * MF_LEN; p++) begin
      int mf, sf, r, blk, b, trib;
      logic expData, expDummy, nextDummy;
      logic [3:0] expReq;
      mf = p / MF_LEN;
      sf = (p % MF_LEN) / SF_LEN;
      r = p % SF_LEN;
      blk = r / BLK_LEN;
      b = r % BLK_LEN;
      if (wePending) begin
        xExp = xPending;
        wePending = 1'b0;
      end
      xBitWe = 1'b0;
      if (blk == 0 && b == 0) stuffLatch = stuffReq[sf];
      // R1 / R9: position strobes
      check(p == 0 ? "R9 start" : "R1 strobes", p, {1'b0, mfStart, sfStart, blkStart},
            {1'b0, 1'(sf == 0 && blk == 0 && b == 0), 1'(blk == 0 && b == 0), 1'(b == 0)});
      trib = (b - 1) % 4;
      expDummy = stuffLatch && blk == 5 && b == sf + 1;
      if (b == 0) begin
        case (blk)
          0: expData = (sf == 0) ? 1'b0 : (sf == 3) ? xExp : 1'b1;
          2: expData = 1'b0;
          5: expData = 1'b1;
          default: expData = stuffLatch;
        endcase
        if (blk == 0 && sf < 3) check("R2 alignment", p, {3'b0, ds2Data}, {3'b0, expData});
        else if (blk == 0) check("R3 spare bit", p, {3'b0, ds2Data}, {3'b0, expData});
        else if (blk == 2 || blk == 5) check("R4 frame bits", p, {3'b0, ds2Data}, {3'b0, expData});
        else check("R5 stuff ctl", p, {3'b0, ds2Data}, {3'b0, expData});
      end else if (expDummy) begin
        check("R8 dummy bit", p, {3'b0, ds2Data}, 4'b0);
      end else begin
        useCnt[trib]++;
        check("R6 interleave", p, {3'b0, ds2Data}, {3'b0, patBit(trib, useCnt[trib])});
      end
      nextDummy = stuffLatch && blk == 5 && b == sf;
      expReq = 4'b0;
      if (b != BLK_LEN - 1 && !nextDummy) expReq[b % 4] = 1'b1;
      check(nextDummy ? "R8 no request" : "R7 request", p, tribReq, expReq);
      for (int t = 0; t < 4; t++) begin
        if (tribReq[t]) begin
          reqCnt[t]++;
          tribBit[t] = patBit(t, reqCnt[t]);
        end
      end
      if (p % MF_LEN == MF_LEN - 1) stuffReq = 4'((mf + 1) * 7);
      if (p % MF_LEN == 100 && mf > 0) begin
        xBitWe = 1'b1;
        xBitIn = 1'(mf >> 1);
        wePending = 1'b1;
        xPending = xBitIn;
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * (NUM_MF * MF_LEN + 2000));
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule